// File: doc/BRIEF.md
# Speculative exception tag register file

This block is a small integer register file in which every register carries one extra bit, the exception tag. Each issued operation presents its source indices, destination index, PC, a result computed outside the block, a raw fault flag and a speculative flag. The block decides what goes into the destination and whether an exception is raised. A speculative operation never traps. If it faults, its own PC is parked in the destination and the tag is set. If it reads a tagged source, that parked PC is carried forward with the tag.

A non-speculative operation acts as the sentinel. If it faults, or if any of its sources is tagged, it raises a one-cycle exception with the PC of the original fault. It then leaves its destination untouched. All tag bits are visible as one status word and can be restored in a single cycle, so that software can save and reload them across a context switch.

Operand values and tags are read combinationally through the source index inputs. An external ALU or load model uses them to form the result for the same cycle. The register update and the exception pulse take effect at the next rising clock edge.

Top module: `spec_tag_regfile`

## Requirements
- R1: After reset every register reads data 0 with a clear tag, `tag_word` is all zeros and `exc_valid` is low.
- R2: A valid speculative operation with both source tags clear and `op_fault` low writes `op_result` to the destination and clears the destination tag.
- R3: A valid speculative operation with both source tags clear and `op_fault` high writes `op_pc` to the destination, sets its tag, and raises no exception.
- R4: A valid speculative operation with a tagged source sets the destination tag and copies that source's data into the destination, whatever `op_fault` is. When both sources are tagged, source 1 is copied.
- R5: A valid non-speculative operation with both source tags clear and `op_fault` low writes `op_result`, clears the destination tag, and raises no exception.
- R6: A valid non-speculative operation with both source tags clear and `op_fault` high raises `exc_valid` in the cycle after issue, with `exc_pc` equal to its `op_pc`. Its destination keeps its data and tag.
- R7: A valid non-speculative operation with a tagged source raises `exc_valid` in the cycle after issue, with `exc_pc` equal to the tagged source's data. Source 1 wins when both are tagged. The destination keeps its data and tag.
- R8: `exc_valid` is high for exactly the one cycle that follows an excepting issue. It is low after any cycle with no valid non-speculative excepting operation.
- R9: Bit i of `tag_word` is the tag of register i. `tag_restore_en` loads every tag from `tag_restore_word` in one cycle, with bit 0 ignored, and leaves all data unchanged.
- R10: When a restore and a writing operation fall in the same cycle, the operation's data is written and all tags take the restored word.
- R11: Register 0 always reads data 0 with a clear tag, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_spec | input | 1 | Operation was moved above a branch (speculative) |
| op_pc | input | XLEN | PC of the operation |
| op_rs1 | input | AW | Source 1 index |
| op_rs2 | input | AW | Source 2 index |
| op_rd | input | AW | Destination index |
| op_result | input | XLEN | Result computed by the external ALU or load model |
| op_fault | input | 1 | Raw fault from the external model |
| src1_data | output | XLEN | Data of register op_rs1 |
| src1_tag | output | 1 | Tag of register op_rs1 |
| src2_data | output | XLEN | Data of register op_rs2 |
| src2_tag | output | 1 | Tag of register op_rs2 |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_pc | output | XLEN | PC reported with the exception |
| tag_word | output | NREG | All tag bits, bit i for register i |
| tag_restore_en | input | 1 | Load all tags from tag_restore_word |
| tag_restore_word | input | NREG | Tag image to restore |

## Verification
Two functions can fall in the same cycle: a tag restore and an operation writeback. Their tag updates then compete for the same destination bit.

The bench provokes this in two ways. Directed cases pair a restore with a speculative faulting write and with a clean write. In the random phase, restores are scattered among operations at random. The result is judged by reading the destination back through the source port. Its data must come from the operation and its tag from the restored word. The status word must equal the restored word with bit 0 cleared, and an exception raised in that same cycle must still be reported.

// File: rtl/spec_tag_pkg.sv
// Shared types for the speculative exception tag register file.
// Assumes nothing beyond IEEE 1800-2017 packages.
package spec_tag_pkg;

    // Which value the writeback path places into the destination data field
    typedef enum logic [1:0] {
        WB_RESULT  = 2'd0,
        WB_OWN_PC  = 2'd1,
        WB_SRC_VAL = 2'd2
    } wb_sel_e;

    // Outcome of applying the deferred-exception rules to one operation
    typedef struct packed {
        logic    wr_en;       // destination is written
        logic    wr_tag;      // tag value written with the data
        wb_sel_e sel;         // data source for the write
        logic    raise;       // exception is signalled
        logic    pc_from_src; // reported PC comes from a tagged source
        logic    pick_src1;   // tagged source chosen is source 1
    } wb_decision_t;

endpackage

// File: rtl/spec_tag_resolve.sv
// Applies the deferred-exception rules to one issued operation.
// Purely combinational. Assumes the source tags are those of the registers
// named by the operation, read before this cycle's update.
module spec_tag_resolve
    import spec_tag_pkg::*;
(
    input  logic         valid,
    input  logic         spec,
    input  logic         fault,
    input  logic         tag1,
    input  logic         tag2,
    output wb_decision_t dec
);

    logic any_tag;

    assign any_tag = tag1 | tag2;

    // Choose write, tag, data source and exception from the five cases
    always_comb begin
        dec             = '0;
        dec.sel         = WB_RESULT;
        dec.pick_src1   = tag1;
        dec.pc_from_src = any_tag;
        if (valid) begin
            if (spec) begin
                dec.wr_en = 1'b1;
                if (any_tag) begin
                    dec.wr_tag = 1'b1;
                    dec.sel    = WB_SRC_VAL;
                end else if (fault) begin
                    dec.wr_tag = 1'b1;
                    dec.sel    = WB_OWN_PC;
                end
            end else begin
                if (any_tag || fault) begin
                    dec.raise = 1'b1;
                end else begin
                    dec.wr_en = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spec_tag_store.sv
// Register storage: NREG entries of XLEN data plus one tag bit each.
// Entry 0 is hard-wired to zero data and a clear tag. Two combinational
// read ports, one write port, and a bulk tag restore that overrides the
// write port's tag update. Synchronous active-low reset.
module spec_tag_store #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            wr_tag,
    input  logic            restore_en,
    input  logic [NREG-1:0] restore_word,
    input  logic [AW-1:0]   ra_idx,
    input  logic [AW-1:0]   rb_idx,
    output logic [XLEN-1:0] ra_data,
    output logic            ra_tag,
    output logic [XLEN-1:0] rb_data,
    output logic            rb_tag,
    output logic [NREG-1:0] tags
);

    logic [XLEN-1:0] data_q [NREG];
    logic [NREG-1:0] tag_q;

    assign data_q[0] = '0;
    assign tag_q[0]  = 1'b0;

    for (genvar i = 1; i < NREG; i++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == AW'(i));

        // Hold one entry's data; written only by the write port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[i] <= '0;
            end else if (hit) begin
                data_q[i] <= wr_data;
            end
        end

        // Hold one entry's tag; a bulk restore beats the write port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[i] <= 1'b0;
            end else if (restore_en) begin
                tag_q[i] <= restore_word[i];
            end else if (hit) begin
                tag_q[i] <= wr_tag;
            end
        end
    end

    assign ra_data = data_q[ra_idx];
    assign ra_tag  = tag_q[ra_idx];
    assign rb_data = data_q[rb_idx];
    assign rb_tag  = tag_q[rb_idx];
    assign tags    = tag_q;

endmodule

// File: rtl/spec_tag_regfile.sv
// Register file with per-register exception tags and deferred-exception
// writeback. Speculative faults are parked as a tagged PC in the
// destination and carried through dependants. A non-speculative consumer
// of a tag, or a non-speculative fault, raises a one-cycle exception and
// leaves its destination untouched. All tags can be read and restored as
// one word. Assumes op_result is formed from src1/src2 in the issue cycle.
module spec_tag_regfile #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic            op_spec,
    input  logic [XLEN-1:0] op_pc,
    input  logic [AW-1:0]   op_rs1,
    input  logic [AW-1:0]   op_rs2,
    input  logic [AW-1:0]   op_rd,
    input  logic [XLEN-1:0] op_result,
    input  logic            op_fault,
    output logic [XLEN-1:0] src1_data,
    output logic            src1_tag,
    output logic [XLEN-1:0] src2_data,
    output logic            src2_tag,
    output logic            exc_valid,
    output logic [XLEN-1:0] exc_pc,
    output logic [NREG-1:0] tag_word,
    input  logic            tag_restore_en,
    input  logic [NREG-1:0] tag_restore_word
);
    import spec_tag_pkg::*;

    wb_decision_t    dec;
    logic [XLEN-1:0] tagged_val;
    logic [XLEN-1:0] wr_data;
    logic [XLEN-1:0] report_pc;

    spec_tag_resolve u_resolve (
        .valid (op_valid),
        .spec  (op_spec),
        .fault (op_fault),
        .tag1  (src1_tag),
        .tag2  (src2_tag),
        .dec   (dec)
    );

    // Pick the tagged source's value, source 1 first
    assign tagged_val = dec.pick_src1 ? src1_data : src2_data;

    // Select the data written to the destination
    always_comb begin
        unique case (dec.sel)
            WB_OWN_PC:  wr_data = op_pc;
            WB_SRC_VAL: wr_data = tagged_val;
            default:    wr_data = op_result;
        endcase
    end

    // Select the PC reported with an exception
    assign report_pc = dec.pc_from_src ? tagged_val : op_pc;

    spec_tag_store #(
        .NREG (NREG),
        .XLEN (XLEN)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (dec.wr_en),
        .wr_idx       (op_rd),
        .wr_data      (wr_data),
        .wr_tag       (dec.wr_tag),
        .restore_en   (tag_restore_en),
        .restore_word (tag_restore_word),
        .ra_idx       (op_rs1),
        .rb_idx       (op_rs2),
        .ra_data      (src1_data),
        .ra_tag       (src1_tag),
        .rb_data      (src2_data),
        .rb_tag       (src2_tag),
        .tags         (tag_word)
    );

    // Register the one-cycle exception pulse and its PC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid <= 1'b0;
            exc_pc    <= '0;
        end else begin
            exc_valid <= dec.raise;
            if (dec.raise) begin
                exc_pc <= report_pc;
            end
        end
    end

endmodule

// File: rtl/spec_tag_regfile_chk.sv
// Property checker for spec_tag_regfile, attached by bind below.
// Observes ports only.
module spec_tag_regfile_chk #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int AW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic            op_spec,
    input logic [XLEN-1:0] op_pc,
    input logic [AW-1:0]   op_rs1,
    input logic            op_fault,
    input logic [XLEN-1:0] src1_data,
    input logic            src1_tag,
    input logic            src2_tag,
    input logic            exc_valid,
    input logic [XLEN-1:0] exc_pc,
    input logic [NREG-1:0] tag_word,
    input logic            tag_restore_en,
    input logic [NREG-1:0] tag_restore_word
);

    AST_SPEC_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_spec) |=> !exc_valid); // R3

    AST_FAULT_OWN_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_spec && !src1_tag && !src2_tag && op_fault)
        |=> (exc_valid && exc_pc == $past(op_pc))); // R6

    AST_TAG_SRC_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_spec && src1_tag)
        |=> (exc_valid && exc_pc == $past(src1_data))); // R7

    AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && !op_spec && (op_fault || src1_tag || src2_tag))
        |=> !exc_valid); // R8

    AST_RESTORE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        tag_restore_en
        |=> (tag_word == ($past(tag_restore_word) & ~NREG'(1)))); // R9

    AST_ZERO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_word[0]); // R11

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (op_rs1 == '0) |-> (src1_data == '0 && !src1_tag)); // R11

endmodule

bind spec_tag_regfile spec_tag_regfile_chk #(
    .NREG (NREG),
    .XLEN (XLEN)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .op_valid         (op_valid),
    .op_spec          (op_spec),
    .op_pc            (op_pc),
    .op_rs1           (op_rs1),
    .op_fault         (op_fault),
    .src1_data        (src1_data),
    .src1_tag         (src1_tag),
    .src2_tag         (src2_tag),
    .exc_valid        (exc_valid),
    .exc_pc           (exc_pc),
    .tag_word         (tag_word),
    .tag_restore_en   (tag_restore_en),
    .tag_restore_word (tag_restore_word)
);

// File: tb/spec_tag_regfile_bench.sv
`timescale 1ns/1ps
// Bench for spec_tag_regfile: directed corner cases, then seeded random
// operations checked against a bench-side model of the tag rules.
module spec_tag_regfile_bench;

    localparam int NREG = 16;
    localparam int XLEN = 32;
    localparam int AW   = $clog2(NREG);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            op_valid, op_spec, op_fault;
    logic [XLEN-1:0] op_pc, op_result;
    logic [AW-1:0]   op_rs1, op_rs2, op_rd;
    logic [XLEN-1:0] src1_data, src2_data, exc_pc;
    logic            src1_tag, src2_tag, exc_valid;
    logic [NREG-1:0] tag_word, tag_restore_word;
    logic            tag_restore_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [XLEN-1:0] m_data [NREG];
    logic            m_tag  [NREG];

    always #2.5 clk = ~clk;

    spec_tag_regfile #(.NREG(NREG), .XLEN(XLEN)) u_spec_tag_regfile (
        .clk, .rst_n, .op_valid, .op_spec, .op_pc, .op_rs1, .op_rs2, .op_rd,
        .op_result, .op_fault, .src1_data, .src1_tag, .src2_data, .src2_tag,
        .exc_valid, .exc_pc, .tag_word, .tag_restore_en, .tag_restore_word
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NREG-1:0] model_tags();
        logic [NREG-1:0] w;
        for (int i = 0; i < NREG; i++) w[i] = m_tag[i];
        return w;
    endfunction

    // Read one register through source port 1 between edges
    task automatic read_reg(input string req, input int idx);
        op_valid = 1'b0;
        op_rs1   = AW'(idx);
        #0.5;
        chk({req, " data"}, 64'(src1_data), 64'(m_data[idx]));
        chk({req, " tag"},  64'(src1_tag),  64'(m_tag[idx]));
    endtask

    task automatic scan_all(input string req);
        for (int i = 0; i < NREG; i++) read_reg(req, i);
        chk({req, " tag_word"}, 64'(tag_word), 64'(model_tags()));
    endtask

    // Issue one operation (optionally with a restore) and check its effect
    task automatic issue(input string req, input bit spec, input int rs1, input int rs2,
                         input int rd, input logic [XLEN-1:0] res, input logic [XLEN-1:0] pc,
                         input bit fault, input bit rst_en, input logic [NREG-1:0] rst_word);
        bit t1, t2, any, e_raise, e_wr, e_tag;
        logic [XLEN-1:0] tval, e_data, e_pc;
        @(negedge clk);
        t1 = m_tag[rs1]; t2 = m_tag[rs2];
        any  = t1 | t2;
        tval = t1 ? m_data[rs1] : m_data[rs2];
        e_raise = 1'b0; e_wr = 1'b0; e_tag = 1'b0; e_data = res; e_pc = pc;
        if (spec) begin
            e_wr = 1'b1;
            if (any) begin e_tag = 1'b1; e_data = tval; end
            else if (fault) begin e_tag = 1'b1; e_data = pc; end
        end else if (any) begin
            e_raise = 1'b1; e_pc = tval;
        end else if (fault) begin
            e_raise = 1'b1;
        end else begin
            e_wr = 1'b1;
        end
        op_valid = 1'b1; op_spec = spec; op_rs1 = AW'(rs1); op_rs2 = AW'(rs2);
        op_rd = AW'(rd); op_result = res; op_pc = pc; op_fault = fault;
        tag_restore_en = rst_en; tag_restore_word = rst_word;
        @(negedge clk);
        op_valid = 1'b0; tag_restore_en = 1'b0;
        if (e_wr && rd != 0) begin
            m_data[rd] = e_data;
            m_tag[rd]  = e_tag;
        end
        if (rst_en) for (int i = 1; i < NREG; i++) m_tag[i] = rst_word[i];
        chk({req, " exc_valid"}, 64'(exc_valid), 64'(e_raise));
        if (e_raise) chk({req, " exc_pc"}, 64'(exc_pc), 64'(e_pc));
        @(negedge clk);
        chk({req, " R8 pulse width"}, 64'(exc_valid), 64'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        rst_n = 1'b0; op_valid = 1'b0; op_spec = 1'b0; op_fault = 1'b0;
        op_pc = '0; op_result = '0; op_rs1 = '0; op_rs2 = '0; op_rd = '0;
        tag_restore_en = 1'b0; tag_restore_word = '0;
        for (int i = 0; i < NREG; i++) begin m_data[i] = '0; m_tag[i] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        scan_all("R1 reset");
        chk("R1 exc_valid", 64'(exc_valid), 64'(0));

        // R2 / R5: clean writes
        issue("R2 spec clean", 1, 0, 0, 1, 32'h1111_0001, 32'h100, 0, 0, '0);
        read_reg("R2", 1);
        issue("R5 nonspec clean", 0, 1, 0, 2, 32'h2222_0002, 32'h104, 0, 0, '0);
        read_reg("R5", 2);
        // R3: speculative fault parks own PC
        issue("R3 spec fault", 1, 1, 2, 3, 32'hdead, 32'h200, 1, 0, '0);
        read_reg("R3", 3);
        // R4: propagation through a dependant, fault flag ignored
        issue("R4 propagate", 1, 2, 3, 4, 32'hbeef, 32'h204, 1, 0, '0);
        read_reg("R4", 4);
        issue("R3 second fault", 1, 0, 0, 5, 32'h0, 32'h300, 1, 0, '0);
        issue("R4 both tagged src1 wins", 1, 5, 3, 6, 32'h0, 32'h304, 0, 0, '0);
        read_reg("R4 priority", 6);
        // R7: sentinel on tagged source, destination untouched
        issue("R7 sentinel src2", 0, 1, 4, 2, 32'h5555, 32'h400, 0, 0, '0);
        read_reg("R7 dest kept", 2);
        issue("R7 both tagged", 0, 3, 5, 1, 32'h5555, 32'h404, 1, 0, '0);
        read_reg("R7 dest kept", 1);
        // R6: non-speculative fault
        issue("R6 nonspec fault", 0, 1, 2, 3, 32'h7777, 32'h500, 1, 0, '0);
        read_reg("R6 dest kept", 3);
        // R5: clean write clears an existing tag
        issue("R5 clears tag", 0, 1, 2, 4, 32'h4444, 32'h504, 0, 0, '0);
        read_reg("R5 tag cleared", 4);
        // R11: register 0 ignores writes
        issue("R11 write r0", 1, 0, 0, 0, 32'hffff, 32'h600, 1, 0, '0);
        read_reg("R11", 0);
        // R9: bulk restore
        issue("R9 restore", 0, 0, 0, 0, 32'h0, 32'h700, 0, 1, 16'hA5A5);
        scan_all("R9");
        // R10: restore and a speculative faulting write in one cycle
        issue("R10 restore+write", 1, 0, 0, 7, 32'h0, 32'h800, 1, 1, 16'h0003);
        scan_all("R10");
        issue("R10 restore+clean", 0, 0, 0, 1, 32'h9999, 32'h804, 0, 1, 16'hFFFE);
        scan_all("R10 clean");
        // R10: restore alongside an excepting sentinel still reports
        issue("R10 restore+exc R7", 0, 1, 0, 2, 32'h0, 32'h808, 0, 1, 16'h0000);
        scan_all("R10 exc");

        // Random phase covering R2-R11
        for (int n = 0; n < 400; n++) begin
            bit rs_en;
            rs_en = ($urandom % 16) == 0;
            issue("R2-R11 random", 1'($urandom % 2), int'($urandom % NREG), int'($urandom % NREG),
                  int'($urandom % NREG), $urandom, $urandom, ($urandom % 4) == 0,
                  rs_en, NREG'($urandom));
            if (n % 25 == 0) scan_all("R2-R11 random scan");
        end
        scan_all("R2-R11 final");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule